// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes incoming Ethernet frames as a byte stream and stores them in the receive region of a shared packet SRAM. The region is a circular ring that occupies the upper part of a 16 KiB byte-addressed memory, from 0x0C00 up to 0x3FFF. Each frame is stored with a four-byte descriptor placed just before it. The descriptor holds a valid marker, a status byte and the stored length. Frames below the Ethernet minimum are zero-padded, and a zeroed four-byte placeholder stands in for the frame check sequence. The pointer is then rounded up to a 16-bit boundary, and four zero bytes are written to blank the next descriptor slot. Only after all of this does the externally visible write pointer move.

The host side supplies its read pointer. From the two pointers the block works out how much of the ring is free, and it offers `rx_ready` only when a maximum-size frame is certain to fit. Oversized frames are accepted off the stream and discarded. When a frame has been committed, the block sets a receive status flag. An interrupt line combines that flag with a transmit flag from a neighbouring block, under a two-bit mask.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `wr_ptr` is 0x0C04, `rx_flag` and `irq` are 0 and no SRAM write is issued.
- R2: The data bytes of an accepted frame are written in arrival order to consecutive ring positions, starting at the value `wr_ptr` had when `rx_start` was accepted.
- R3: After the data, (64 − len) zero bytes follow when len < 64, and then 4 zero bytes. One frame issues exactly len + pad + 8 SRAM writes.
- R4: After the padding, the position is rounded up to even. Four zero bytes are written there, and the new `wr_ptr` is the position after them. `wr_ptr` is therefore always even.
- R5: The four ring positions before the old pointer receive, in ascending order, 0x01, 0x00, the low byte and then the high byte of the stored length. The stored length is max(len, 64) + 4.
- R6: The ring position after 0x3FFF is 0x0C00. The positions before 0x0C00 wrap to the top of the ring, so every SRAM write lies in 0x0C00..0x3FFF.
- R7: A frame with len > 2048 is consumed up to its `rx_end`. It causes no SRAM write, leaves `wr_ptr` unchanged and does not set `rx_flag`.
- R8: Free space is `rd_ptr` − `wr_ptr` when `wr_ptr` < `rd_ptr`, and 13312 − (`wr_ptr` − `rd_ptr`) otherwise. `rx_ready` is high in idle only if the free space seen one cycle earlier exceeds 2048. A start pulse while `rx_ready` is low is ignored.
- R9: `rx_ready` is low, and no new frame is accepted, from the cycle after an accepted start until the frame is fully written.
- R10: `wr_ptr` changes only when a frame commits, and `rx_flag` becomes 1 on that same clock edge.
- R11: A one-cycle `flag_clr` pulse clears `rx_flag`.
- R12: `irq` is registered and equals the OR over bit 0 (`rx_flag`) and bit 1 (`tx_flag`) of the flags ANDed with `irq_mask`. It follows a change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Frame start pulse, carries `rx_len` |
| rx_len | input | 12 | Frame length in bytes (1..4095) |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_end | input | 1 | Marks the last data byte |
| rd_ptr | input | 14 | Host read pointer into the ring |
| irq_mask | input | 2 | Interrupt mask, bit 0 receive, bit 1 transmit |
| tx_flag | input | 1 | Transmit-done flag from the neighbouring block |
| flag_clr | input | 1 | Clears `rx_flag` |
| rx_ready | output | 1 | A frame start will be accepted |
| mem_we | output | 1 | SRAM byte write enable |
| mem_addr | output | 14 | SRAM byte address |
| mem_wdata | output | 8 | SRAM byte data |
| wr_ptr | output | 14 | Committed receive write pointer |
| rx_flag | output | 1 | Frame-received status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every frame length from 1 to 70, so it crosses the 64-byte padding threshold and both pointer parities. A design that mis-sized the padding, skipped the even rounding or wrote the length without the four extra bytes would leave wrong bytes in the ring, or would end on a wrong pointer. The bench then places a frame so that the blanked descriptor slot straddles 0x3FFF/0x0C00. A writer that forgot the wrap when it stepped backwards for the descriptor would write below the ring. Further cases cover free space exactly at 2048 against 2049, start pulses while not ready, and lengths of 2048 against 2049 and above. An off-by-one comparison there would either block a legal frame or overwrite unread data.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_CLR,
    ST_HDR,
    ST_DONE
  } rxr_state_t;

  localparam int HDR_BYTES = 4;
  localparam logic [7:0] HDR_MARK = 8'h01;
  localparam logic [7:0] HDR_STAT = 8'h00;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int ADDR_W    = 14,
  parameter int RING_BASE = 'h0C00,
  parameter int MAX_FRAME = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic              space_ok
);
  localparam int AW1  = ADDR_W + 1;
  localparam int SPAN = (1 << ADDR_W) - RING_BASE;
  localparam logic [ADDR_W:0] SPAN_V = AW1'(SPAN);
  localparam logic [ADDR_W:0] MAX_V  = AW1'(MAX_FRAME);

  logic [ADDR_W:0] free_w;

  always_comb begin
    if (rd_ptr > wr_ptr) free_w = {1'b0, rd_ptr} - {1'b0, wr_ptr};
    else                 free_w = SPAN_V - ({1'b0, wr_ptr} - {1'b0, rd_ptr});
  end

  always_ff @(posedge clk) begin
    if (rst) space_ok <= 1'b0;
    else     space_ok <= (free_w > MAX_V);
  end
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int LEN_W     = 12,
  parameter int RING_BASE = 'h0C00,
  parameter int PTR_RESET = 'h0C04,
  parameter int MAX_FRAME = 2048,
  parameter int MIN_FRAME = 64,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_start,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_end,
  input  logic              space_ok,
  output logic              rx_ready,
  output logic              commit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] wr_ptr
);
  localparam int AW1  = ADDR_W + 1;
  localparam int SPAN = (1 << ADDR_W) - RING_BASE;
  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(RING_BASE);
  localparam logic [ADDR_W-1:0] RST_V   = ADDR_W'(PTR_RESET);
  localparam logic [LEN_W-1:0]  MIN_V   = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0]  MAX_V   = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0]  CRC_V   = LEN_W'(CRC_BYTES);
  localparam logic [LEN_W-1:0]  SLOT_V  = LEN_W'(HDR_BYTES);

  rxr_state_t        state_q;
  logic [ADDR_W-1:0] cur_q, base_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [1:0]        hidx_q;
  logic [15:0]       stored_len;
  logic [LEN_W-1:0]  pad_total;
  logic [7:0]        hdr_byte;
  logic [ADDR_W-1:0] hdr_addr;

  // one step forward in the ring
  function automatic logic [ADDR_W-1:0] ring_inc(input logic [ADDR_W-1:0] p);
    if (p == {ADDR_W{1'b1}}) return BASE_V;
    return p + 1'b1;
  endfunction

  // round an odd position up to the next even one, wrapping
  function automatic logic [ADDR_W-1:0] ring_even(input logic [ADDR_W-1:0] p);
    if (p[0]) return ring_inc(p);
    return p;
  endfunction

  // k steps backwards in the ring
  function automatic logic [ADDR_W-1:0] ring_back(input logic [ADDR_W-1:0] p,
                                                  input logic [2:0] k);
    logic [ADDR_W:0] t;
    t = {1'b0, p} - AW1'(k);
    if (t < {1'b0, BASE_V}) t = t + AW1'(SPAN);
    return t[ADDR_W-1:0];
  endfunction

  always_comb begin
    stored_len = 16'((len_q < MIN_V) ? MIN_V : len_q) + 16'(CRC_BYTES);
    pad_total  = ((len_q < MIN_V) ? (MIN_V - len_q) : '0) + CRC_V;
    hdr_addr   = ring_back(base_q, 3'd4 - {1'b0, hidx_q});
    unique case (hidx_q)
      2'd0:    hdr_byte = HDR_MARK;
      2'd1:    hdr_byte = HDR_STAT;
      2'd2:    hdr_byte = stored_len[7:0];
      default: hdr_byte = stored_len[15:8];
    endcase
  end

  assign rx_ready = (state_q == ST_IDLE) && space_ok;
  assign commit   = (state_q == ST_HDR) && (hidx_q == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_q     <= RST_V;
      base_q    <= RST_V;
      len_q     <= '0;
      cnt_q     <= '0;
      hidx_q    <= '0;
      wr_ptr    <= RST_V;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rx_start && rx_ready) begin
            len_q   <= rx_len;
            cur_q   <= wr_ptr;
            base_q  <= wr_ptr;
            state_q <= (rx_len > MAX_V) ? ST_DROP : ST_DATA;
          end
        end
        ST_DATA: begin
          if (rx_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_q;
            mem_wdata <= rx_data;
            cur_q     <= ring_inc(cur_q);
            if (rx_end) begin
              cnt_q   <= pad_total;
              state_q <= ST_PAD;
            end
          end
        end
        ST_DROP: begin
          if (rx_valid && rx_end) state_q <= ST_IDLE;
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_q;
          mem_wdata <= 8'h00;
          if (cnt_q == LEN_W'(1)) begin
            cur_q   <= ring_even(ring_inc(cur_q));
            cnt_q   <= SLOT_V;
            state_q <= ST_CLR;
          end else begin
            cur_q <= ring_inc(cur_q);
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CLR: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_q;
          mem_wdata <= 8'h00;
          cur_q     <= ring_inc(cur_q);
          if (cnt_q == LEN_W'(1)) begin
            hidx_q  <= 2'd0;
            state_q <= ST_HDR;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= hdr_addr;
          mem_wdata <= hdr_byte;
          hidx_q    <= hidx_q + 1'b1;
          if (hidx_q == 2'd3) begin
            wr_ptr  <= cur_q;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       commit,
  input  logic       flag_clr,
  input  logic       tx_flag,
  input  logic [1:0] irq_mask,
  output logic       rx_flag,
  output logic       irq
);
  logic flag_d;

  always_comb flag_d = commit | (rx_flag & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rx_flag <= flag_d;
      irq     <= |({tx_flag, flag_d} & irq_mask);
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W    = 14,
  parameter int LEN_W     = 12,
  parameter int RING_BASE = 'h0C00,
  parameter int PTR_RESET = 'h0C04,
  parameter int MAX_FRAME = 2048,
  parameter int MIN_FRAME = 64,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_start,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_end,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [1:0]        irq_mask,
  input  logic              tx_flag,
  input  logic              flag_clr,
  output logic              rx_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              rx_flag,
  output logic              irq
);
  logic space_ok;
  logic commit;

  rxr_space #(
    .ADDR_W(ADDR_W), .RING_BASE(RING_BASE), .MAX_FRAME(MAX_FRAME)
  ) u_space (
    .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .space_ok(space_ok)
  );

  rxr_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RING_BASE(RING_BASE), .PTR_RESET(PTR_RESET),
    .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME), .CRC_BYTES(CRC_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_len(rx_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
    .space_ok(space_ok), .rx_ready(rx_ready), .commit(commit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr)
  );

  rxr_irq u_irq (
    .clk(clk), .rst(rst), .commit(commit), .flag_clr(flag_clr),
    .tx_flag(tx_flag), .irq_mask(irq_mask), .rx_flag(rx_flag), .irq(irq)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int ADDR_W    = 14,
  parameter int RING_BASE = 'h0C00,
  parameter int PTR_RESET = 'h0C04,
  parameter int MAX_FRAME = 2048
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [1:0]        irq_mask,
  input logic              rx_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              rx_flag,
  input logic              irq
);
  localparam int SPAN = (1 << ADDR_W) - RING_BASE;

  function automatic int room(input logic [ADDR_W-1:0] w, input logic [ADDR_W-1:0] r);
    if (int'(w) < int'(r)) return int'(r) - int'(w);
    return SPAN - (int'(w) - int'(r));
  endfunction

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_ptr == ADDR_W'(PTR_RESET)) && !rx_flag && !irq && !mem_we);

  // R6
  a_r6_write_in_ring: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_addr) >= RING_BASE));

  // R4
  a_r4_ptr_even: assert property (@(posedge clk) disable iff (rst)
    !wr_ptr[0] && (int'(wr_ptr) >= RING_BASE));

  // R8
  a_r8_ready_room: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (room($past(wr_ptr), $past(rd_ptr)) > MAX_FRAME));

  // R9
  a_r9_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !mem_we);

  // R10
  a_r10_ptr_with_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> rx_flag);

  // R12
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_mask) == 2'b00) |-> !irq);
endmodule

bind rx_ring_writer rxr_checker #(
  .ADDR_W(ADDR_W), .RING_BASE(RING_BASE), .PTR_RESET(PTR_RESET), .MAX_FRAME(MAX_FRAME)
) u_chk (
  .clk(clk), .rst(rst), .rd_ptr(rd_ptr), .irq_mask(irq_mask), .rx_ready(rx_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .wr_ptr(wr_ptr), .rx_flag(rx_flag), .irq(irq)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int TOP  = 16384;
  localparam int BASE = 'h0C00;
  localparam int SPAN = TOP - BASE;

  logic        clk = 0;
  logic        rst = 1;
  logic        rx_start = 0;
  logic [11:0] rx_len = '0;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_end = 0;
  logic [13:0] rd_ptr = 14'h0C04;
  logic [1:0]  irq_mask = 2'b00;
  logic        tx_flag = 0;
  logic        flag_clr = 0;
  logic        rx_ready, mem_we, rx_flag, irq;
  logic [13:0] mem_addr, wr_ptr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  logic [7:0] mem [0:TOP-1];

  always #5 clk = ~clk;

  rx_ring_writer dut (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_len(rx_len), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rd_ptr(rd_ptr), .irq_mask(irq_mask),
    .tx_flag(tx_flag), .flag_clr(flag_clr), .rx_ready(rx_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .rx_flag(rx_flag),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  function automatic int nxt(input int p);
    return (p == TOP - 1) ? BASE : p + 1;
  endfunction

  function automatic int back(input int p, input int k);
    int t = p - k;
    if (t < BASE) t = t + SPAN;
    return t;
  endfunction

  function automatic int room(input int w, input int r);
    return (w < r) ? r - w : SPAN - (w - r);
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 13) + (seed * 7) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic pulse_clr();
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    @(negedge clk);
  endtask

  // sends one frame with rd_ptr parked at wr_ptr, then checks the ring image
  task automatic send_frame(input int len, input int seed);
    int p0, c0, p, e, pad, stored, nw;
    rd_ptr = wr_ptr;
    pulse_clr();
    @(negedge clk);
    wait_ready();
    p0 = int'(wr_ptr);
    c0 = wr_cnt;
    rx_start = 1;
    rx_len = 12'(len);
    @(negedge clk);
    rx_start = 0;
    chk(!rx_ready, "R9 ready low after start", int'(rx_ready), 0);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1;
      rx_data = pat(i, seed);
      rx_end = (i == len - 1);
      @(negedge clk);
    end
    rx_valid = 0;
    rx_end = 0;
    wait_ready();
    nw = wr_cnt - c0;
    if (len > 2048) begin
      chk(nw == 0, "R7 no writes on drop", nw, 0);
      chk(int'(wr_ptr) == p0, "R7 ptr kept on drop", int'(wr_ptr), p0);
      chk(!rx_flag, "R7 flag not set on drop", int'(rx_flag), 0);
    end else begin
      pad = ((len < 64) ? 64 - len : 0) + 4;
      stored = ((len < 64) ? 64 : len) + 4;
      p = p0;
      e = 0;
      for (int i = 0; i < len; i++) begin
        if (mem[p] != pat(i, seed)) e++;
        p = nxt(p);
      end
      chk(e == 0, "R2 data bytes", e, 0);
      e = 0;
      for (int i = 0; i < pad; i++) begin
        if (mem[p] != 8'h00) e++;
        p = nxt(p);
      end
      chk(e == 0, "R3 pad and crc zero", e, 0);
      chk(nw == len + pad + 8, "R3 write count", nw, len + pad + 8);
      if (p % 2 == 1) p = nxt(p);
      e = 0;
      for (int i = 0; i < 4; i++) begin
        if (mem[p] != 8'h00) e++;
        p = nxt(p);
      end
      chk(e == 0, "R4 next slot cleared", e, 0);
      chk(int'(wr_ptr) == p, "R4 new pointer", int'(wr_ptr), p);
      chk(mem[back(p0, 4)] == 8'h01 && mem[back(p0, 3)] == 8'h00, "R5 header mark",
          {mem[back(p0, 4)], mem[back(p0, 3)]}, 16'h0100);
      chk({mem[back(p0, 1)], mem[back(p0, 2)]} == 16'(stored), "R5 header length",
          {mem[back(p0, 1)], mem[back(p0, 2)]}, stored);
      chk(rx_flag, "R10 flag after commit", int'(rx_flag), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, r, d, c0;
    for (int i = 0; i < TOP; i++) mem[i] = 8'hEE;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(wr_ptr == 14'h0C04, "R1 reset pointer", int'(wr_ptr), 'h0C04);
    chk(!rx_flag && !irq, "R1 flag and irq low", {rx_flag, irq}, 0);
    chk(wr_cnt == 0, "R1 no writes", wr_cnt, 0);
    chk(rx_ready, "R8 ready with empty ring", int'(rx_ready), 1);

    // length sweep across padding threshold and both parities
    for (int len = 1; len <= 70; len++) send_frame(len, len);
    send_frame(127, 3);
    send_frame(128, 4);
    send_frame(2047, 5);
    send_frame(2048, 6);

    // free space boundaries (R8)
    w = int'(wr_ptr);
    rd_ptr = 14'(w + 2048);
    repeat (2) @(negedge clk);
    chk(!rx_ready, "R8 room 2048 not enough", int'(rx_ready), 0);
    c0 = wr_cnt;
    rx_start = 1;
    rx_len = 12'd10;
    @(negedge clk);
    rx_start = 0;
    repeat (4) @(negedge clk);
    chk(int'(wr_ptr) == w && wr_cnt == c0, "R8 start ignored when not ready",
        int'(wr_ptr), w);
    rd_ptr = 14'(w + 2049);
    repeat (2) @(negedge clk);
    chk(rx_ready, "R8 room 2049 enough", int'(rx_ready), 1);
    r = (w - 5000 >= BASE) ? w - 5000 : BASE;
    rd_ptr = 14'(r);
    repeat (2) @(negedge clk);
    chk(rx_ready == (room(w, r) > 2048), "R8 wrapped room", int'(rx_ready),
        int'(room(w, r) > 2048));
    send_frame(40, 9);

    // oversize frames (R7)
    send_frame(2049, 11);
    send_frame(3000, 12);

    // flag and interrupt (R11, R12)
    send_frame(20, 13);
    irq_mask = 2'b01;
    repeat (2) @(negedge clk);
    chk(irq, "R12 irq from rx flag", int'(irq), 1);
    irq_mask = 2'b00;
    repeat (2) @(negedge clk);
    chk(!irq, "R12 masked rx flag", int'(irq), 0);
    irq_mask = 2'b01;
    pulse_clr();
    chk(!rx_flag, "R11 flag cleared", int'(rx_flag), 0);
    chk(!irq, "R12 irq low after clear", int'(irq), 0);
    tx_flag = 1;
    irq_mask = 2'b10;
    repeat (2) @(negedge clk);
    chk(irq, "R12 irq from tx flag", int'(irq), 1);
    irq_mask = 2'b01;
    repeat (2) @(negedge clk);
    chk(!irq, "R12 tx flag masked", int'(irq), 0);
    tx_flag = 0;
    irq_mask = 2'b00;

    // drive the pointer up to the top, then straddle the wrap (R6)
    d = TOP - int'(wr_ptr);
    while (d - 6 > 2048) begin
      send_frame(((d - 1006) < 2000) ? (d - 1006) : 2000, d);
      d = TOP - int'(wr_ptr);
    end
    if (d - 6 >= 64) begin
      send_frame(d - 6, 21);
      chk(wr_ptr == 14'h0C02, "R6 slot straddles wrap", int'(wr_ptr), 'h0C02);
    end else begin
      chk(0, "R6 wrap placement", d, 70);
    end
    send_frame(65, 22);
    send_frame(64, 23);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule